// File: doc/BRIEF.md
# Sectored Almost-Flag Status Bus

This block reports per-queue almost-empty (or almost-full) flags of a sixteen-queue buffer over a narrow eight-bit status bus. The queues are grouped into sectors of eight, so the default build has two sectors. Only one sector is visible on the bus at a time. The flags come in and go out active low, unchanged in value.

The block has two modes, and the mode is captured while master reset is held. In direct mode, an external controller picks a sector by pulsing a strobe together with a sector address, and the bus keeps showing that sector until the next strobe. In polled mode, the block steps through the sectors by itself, one per clock edge. A sync output marks the cycles in which sector 0 is on the bus.

An enable input releases the bus to high impedance, so several such blocks can share one set of wires. The bus carries status only. It has no valid/ready handshake and no back-pressure: the selected sector's flags are shown live in every cycle, and a reader samples them whenever it likes.

Top module: `afb_flag_bus`

## Requirements
- R1: Bit k of `flag_bus` carries `flags_n[s*8+k]`, where s is the sector on display. The bits are passed through with their active-low value unchanged (0 = queue almost empty or almost full).
- R2: `mode_sel` is sampled on every rising edge while `rst_n` is low (1 = polled, 0 = direct). Changes on `mode_sel` after reset is released have no effect on the bus or on `sync`.
- R3: In direct mode, a rising edge with `strobe` high selects sector `sector_addr`. That sector is on the bus from that edge on.
- R4: In direct mode, with `strobe` low, the displayed sector is held. The bus follows the current flag values of that sector.
- R5: In polled mode, each rising edge advances the displayed sector by one, wrapping from the last sector to sector 0. `strobe` and `sector_addr` are ignored.
- R6: `sync` is high in polled mode exactly while sector 0 is displayed, and is always low in direct mode.
- R7: When `bus_en` is low, every bit of `flag_bus` is high impedance. Sector sequencing continues unaffected.
- R8: Immediately after reset is released, sector 0 is displayed, and in polled mode stepping starts from sector 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Master reset, active low, asynchronous assertion for the sector pointer |
| mode_sel | input | 1 | Mode choice sampled during reset: 1 polled, 0 direct |
| flags_n | input | 16 | Per-queue active-low almost flags, queue i on bit i |
| strobe | input | 1 | Sector selection strobe for direct mode |
| sector_addr | input | 1 | Sector number loaded on a strobe |
| bus_en | input | 1 | High drives the status bus, low floats it |
| flag_bus | output | 8 | Active-low flags of the displayed sector, or high impedance |
| sync | output | 1 | High while sector 0 is displayed in polled mode |

## Verification
The assertions assume that `strobe` and `sector_addr` are known, and that any strobe addresses an existing sector. They also assume that `mode_sel` reflects the intended mode at the last clock edge before reset is released. The stimulus changes every input only on falling clock edges. It draws addresses modulo the sector count and holds `mode_sel` steady through each reset window. It then toggles `mode_sel` freely once running, to show that the value is ignored after reset.

// File: rtl/afb_pkg.sv
package afb_pkg;

  typedef enum logic {
    MODE_DIRECT = 1'b0,
    MODE_POLLED = 1'b1
  } flag_mode_e;

  function automatic int sector_addr_width(input int num_sectors);
    return (num_sectors > 1) ? $clog2(num_sectors) : 1;
  endfunction

endpackage

// File: rtl/afb_sector_seq.sv
module afb_sector_seq
  import afb_pkg::*;
#(
  parameter int NUM_SECTORS = 2,
  parameter int SAW         = sector_addr_width(NUM_SECTORS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_sel,
  input  logic           strobe,
  input  logic [SAW-1:0] sector_addr,
  output flag_mode_e     mode_o,
  output logic [SAW-1:0] sector_o,
  output logic           sync_o
);

  localparam logic [SAW-1:0] LAST_SECTOR = SAW'(NUM_SECTORS - 1);

  flag_mode_e     mode_q;
  logic [SAW-1:0] sector_q;
  logic           addr_ok;

  assign addr_ok = (32'(sector_addr) < NUM_SECTORS);

  // Mode is captured on clock edges only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= flag_mode_e'(mode_sel);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sector_q <= '0;
    end else if (mode_q == MODE_POLLED) begin
      sector_q <= (sector_q == LAST_SECTOR) ? '0 : sector_q + 1'b1;
    end else if (strobe && addr_ok) begin
      sector_q <= sector_addr;
    end
  end

  assign mode_o   = mode_q;
  assign sector_o = sector_q;
  assign sync_o   = (mode_q == MODE_POLLED) && (sector_q == '0);

  // R2: mode frozen once reset has been released
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (mode_q == $past(mode_q)));

  // R5: polled mode steps one sector per edge with wrap
  p_poll_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_POLLED) |=>
      (sector_q == (($past(sector_q) == LAST_SECTOR) ? '0 : $past(sector_q) + 1'b1)));

  // R3: strobe in direct mode loads the addressed sector
  p_direct_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_DIRECT) && strobe && addr_ok) |=> (sector_q == $past(sector_addr)));

  // R4: no strobe in direct mode keeps the sector
  p_direct_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_DIRECT) && !strobe) |=> $stable(sector_q));

  generate
    if (NUM_SECTORS > 1) begin : g_sync_chk
      // R6: sync lasts a single cycle per round
      p_sync_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_o && $past(rst_n)) |=> !sync_o);
    end
  endgenerate

endmodule

// File: rtl/afb_sector_mux.sv
module afb_sector_mux #(
  parameter int NUM_QUEUES   = 16,
  parameter int SECTOR_WIDTH = 8,
  parameter int NUM_SECTORS  = NUM_QUEUES / SECTOR_WIDTH,
  parameter int SAW          = 1
) (
  input  logic [NUM_QUEUES-1:0]   flags_n,
  input  logic [SAW-1:0]          sel,
  output logic [SECTOR_WIDTH-1:0] sector_flags_n
);

  logic [SECTOR_WIDTH-1:0] sectors [NUM_SECTORS];

  generate
    for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_sector
      assign sectors[g] = flags_n[g*SECTOR_WIDTH +: SECTOR_WIDTH];
    end
  endgenerate

  always_comb begin
    sector_flags_n = '1;
    for (int s = 0; s < NUM_SECTORS; s++) begin
      if (32'(sel) == s) sector_flags_n = sectors[s];
    end
  end

endmodule

// File: rtl/afb_bus_drive.sv
module afb_bus_drive #(
  parameter int WIDTH = 8
) (
  input  logic             en,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] bus
);

  assign bus = en ? data : {WIDTH{1'bz}};

endmodule

// File: rtl/afb_flag_bus.sv
module afb_flag_bus
  import afb_pkg::*;
#(
  parameter int NUM_QUEUES   = 16,
  parameter int SECTOR_WIDTH = 8
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           mode_sel,
  input  logic [NUM_QUEUES-1:0]                          flags_n,
  input  logic                                           strobe,
  input  logic [sector_addr_width(NUM_QUEUES/SECTOR_WIDTH)-1:0] sector_addr,
  input  logic                                           bus_en,
  output logic [SECTOR_WIDTH-1:0]                        flag_bus,
  output logic                                           sync
);

  localparam int NUM_SECTORS = NUM_QUEUES / SECTOR_WIDTH;
  localparam int SAW         = sector_addr_width(NUM_SECTORS);

  flag_mode_e              mode;
  logic [SAW-1:0]          sector;
  logic [SECTOR_WIDTH-1:0] shown_n;

  afb_sector_seq #(
    .NUM_SECTORS(NUM_SECTORS),
    .SAW        (SAW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .strobe     (strobe),
    .sector_addr(sector_addr),
    .mode_o     (mode),
    .sector_o   (sector),
    .sync_o     (sync)
  );

  afb_sector_mux #(
    .NUM_QUEUES  (NUM_QUEUES),
    .SECTOR_WIDTH(SECTOR_WIDTH),
    .NUM_SECTORS (NUM_SECTORS),
    .SAW         (SAW)
  ) u_mux (
    .flags_n       (flags_n),
    .sel           (sector),
    .sector_flags_n(shown_n)
  );

  afb_bus_drive #(
    .WIDTH(SECTOR_WIDTH)
  ) u_drv (
    .en  (bus_en),
    .data(shown_n),
    .bus (flag_bus)
  );

  // R6: sync only ever appears in polled mode
  p_sync_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> (mode == MODE_POLLED));

endmodule

// File: tb/sim_afb_flag_bus.sv
module sim_afb_flag_bus;
  localparam int NQ = 16;
  localparam int SW = 8;
  localparam int NS = NQ / SW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_sel = 1'b0;
  logic [NQ-1:0] flags_n = '1;
  logic          strobe = 1'b0;
  logic [0:0]    sector_addr = '0;
  logic          bus_en = 1'b1;
  logic [SW-1:0] flag_bus;
  logic          sync;

  int    checks = 0;
  int    errors = 0;
  string phase  = "R8";
  int    m_ptr  = 0;
  bit    m_mode = 1'b0;

  always #10 clk = ~clk;

  afb_flag_bus #(.NUM_QUEUES(NQ), .SECTOR_WIDTH(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .flags_n(flags_n),
    .strobe(strobe), .sector_addr(sector_addr), .bus_en(bus_en),
    .flag_bus(flag_bus), .sync(sync)
  );

  // Behavioural reference: sector index and latched mode.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = mode_sel;
      m_ptr  = 0;
    end else if (m_mode) begin
      m_ptr = (m_ptr + 1) % NS;
    end else if (strobe) begin
      m_ptr = int'(sector_addr);
    end
  end

  task automatic compare();
    logic [SW-1:0] exp_bus;
    logic          exp_sync;
    if (!rst_n) return;
    exp_bus  = bus_en ? flags_n[m_ptr*SW +: SW] : {SW{1'bz}};
    exp_sync = m_mode && (m_ptr == 0);
    checks++;
    if (flag_bus !== exp_bus) begin
      errors++;
      $display("FAIL %s flag_bus actual=%b expected=%b", phase, flag_bus, exp_bus);
    end
    checks++;
    if (sync !== exp_sync) begin
      errors++;
      $display("FAIL %s sync actual=%b expected=%b", phase, sync, exp_sync);
    end
  endtask

  task automatic step(input bit rnd_strobe, input bit rnd_en, input bit rnd_mode);
    @(negedge clk);
    compare();
    flags_n     = NQ'($urandom);
    strobe      = rnd_strobe ? 1'($urandom % 2) : 1'b0;
    sector_addr = 1'($urandom % NS);
    if (rnd_en)   bus_en   = 1'($urandom % 2);
    if (rnd_mode) mode_sel = 1'($urandom % 2);
  endtask

  task automatic do_reset(input bit m);
    @(negedge clk);
    rst_n    = 1'b0;
    mode_sel = m;
    strobe   = 1'b0;
    bus_en   = 1'b1;
    flags_n  = NQ'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    phase = "R8";
    compare();   // sector 0 right after release
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    phase = "R3"; repeat (40) step(1'b1, 1'b0, 1'b0);
    phase = "R4"; repeat (20) step(1'b0, 1'b0, 1'b0);
    phase = "R7"; repeat (20) step(1'b1, 1'b1, 1'b0);
    bus_en = 1'b1;
    phase = "R2"; repeat (20) step(1'b1, 1'b0, 1'b1);

    do_reset(1'b1);
    phase = "R5"; repeat (40) step(1'b1, 1'b0, 1'b0);
    phase = "R6"; repeat (20) step(1'b1, 1'b1, 1'b1);
    bus_en = 1'b1;

    // R1: fixed pattern, select sector 1 and look for the upper byte
    do_reset(1'b0);
    phase = "R1";
    @(negedge clk);
    flags_n = 16'h5AC3; strobe = 1'b1; sector_addr = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    compare();
    checks++;
    if (flag_bus !== 8'h5A) begin
      errors++;
      $display("FAIL R1 flag_bus actual=%h expected=%h", flag_bus, 8'h5A);
    end
    repeat (5) step(1'b1, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule